// File: doc/BRIEF.md
# Converter Result Serial Master Port

This block sends a finished conversion word out over a three-wire serial link that it drives itself: a bit clock, a frame strobe and one data line. A one-cycle done pulse stores the result in a holding register and raises a pending flag. The block starts a frame once the busy flag of the converter allows it. In read-after mode it waits for busy to be low. In read-during mode it sends the stored (previous) result while busy is high for the next conversion.

The bit clock runs at the system clock divided by 2, 4, 8 or 16, picked by a two-bit select. The clock level and the frame level can each be inverted. When no frame is running, the clock and frame lines sit at their idle levels and the data line is held low.

Top module: `conv_serial_master`

## Requirements
- R1: A frame carries exactly 16 data bits, most significant bit first. One bit is taken per active clock edge, which is the rising edge of the un-inverted clock.
- R2: The clock half period is 2^div_sel_i system cycles (1, 2, 4, 8 for codes 0 to 3), so the period doubles with each code step. The select is sampled when a frame starts.
- R3: With read_during_i = 0, a pending result starts a frame only while busy_i is low. No frame starts while busy_i stays high.
- R4: With read_during_i = 1, a pending result starts a frame only while busy_i is high. No frame starts while busy_i is low.
- R5: sclk_o equals the raw clock XOR sclk_inv_i, and sync_o equals the raw frame XOR sync_inv_i. Raw clock idle is 0, raw frame active is 1, and the frame is inactive at 0.
- R6: The frame becomes active exactly one half period before the first active clock edge. It returns to inactive exactly one half period after the clock returns to idle following the last bit.
- R7: Within a frame, sdout_o changes only on the inactive (falling raw) clock edge.
- R8: A done pulse during a frame stores its result for a later frame without disturbing the current frame's bits. The stored result is sent in the next frame.
- R9: After reset, and whenever no frame is active, the clock and frame lines sit at their idle levels and sdout_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result_i | input | 16 | Conversion result, captured on done_i |
| done_i | input | 1 | One-cycle pulse: result_i is valid |
| busy_i | input | 1 | Converter busy flag |
| div_sel_i | input | 2 | Clock divide code |
| read_during_i | input | 1 | 1 = send previous result during conversion |
| sclk_inv_i | input | 1 | Inverts the serial clock level |
| sync_inv_i | input | 1 | Inverts the frame strobe level |
| sclk_o | output | 1 | Serial clock |
| sync_o | output | 1 | Frame strobe |
| sdout_o | output | 1 | Serial data, MSB first |

## Verification
Random words, divide codes, polarities and modes are sent frame by frame. A receiver model in the bench rebuilds each word from the active edges and measures the clock high time, the frame lead and the frame trail. This separates bit-order and divide errors from polarity errors. All-zero, all-one, alternating and end-bit-only words show whether the first or last bit is lost or shifted. Holding busy at the blocking level after a done pulse shows whether the start condition is obeyed in each mode. A second done pulse inside a running frame shows whether the holding register is kept apart from the shift register.

// File: rtl/conv_serial_master.sv
module conv_serial_master #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] result_i,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic              read_during_i,
  input  logic              sclk_inv_i,
  input  logic              sync_inv_i,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              sdout_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam int BIT_W = $clog2(DATA_W);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TRAIL} st_t;

  st_t               st_q;
  logic [DATA_W-1:0] hold_q, sh_q;
  logic              pend_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ph_q;
  logic [BIT_W-1:0]  nb_q;
  logic              sclk_q, sync_q;

  logic [CNT_W:0]    half_len;
  logic              hit, go;

  assign half_len = {{CNT_W{1'b0}}, 1'b1} << div_q;
  assign hit      = ({1'b0, cnt_q} == (half_len - 1'b1));
  assign go       = (st_q == S_IDLE) && pend_q && (read_during_i ? busy_i : !busy_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      hold_q <= '0;
      sh_q   <= '0;
      pend_q <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      nb_q   <= '0;
      sclk_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      if (done_i) begin
        hold_q <= result_i;
        pend_q <= 1'b1;
      end else if (go) begin
        pend_q <= 1'b0;
      end
      case (st_q)
        S_IDLE: if (go) begin
          st_q   <= S_SHIFT;
          sh_q   <= hold_q;
          div_q  <= div_sel_i;
          cnt_q  <= '0;
          ph_q   <= 1'b0;
          nb_q   <= BIT_W'(DATA_W - 1);
          sync_q <= 1'b1;
          sclk_q <= 1'b0;
        end
        S_SHIFT: if (hit) begin
          cnt_q <= '0;
          if (!ph_q) begin
            ph_q   <= 1'b1;
            sclk_q <= 1'b1;
          end else begin
            ph_q   <= 1'b0;
            sclk_q <= 1'b0;
            if (nb_q == '0) st_q <= S_TRAIL;
            else begin
              nb_q <= nb_q - 1'b1;
              sh_q <= sh_q << 1;
            end
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        S_TRAIL: if (hit) begin
          st_q   <= S_IDLE;
          sync_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign sclk_o  = sclk_q ^ sclk_inv_i;
  assign sync_o  = sync_q ^ sync_inv_i;
  assign sdout_o = sync_q & sh_q[DATA_W-1];
endmodule

// File: rtl/conv_serial_master_chk.sv
module conv_serial_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_i,
  input logic read_during_i,
  input logic sclk_q,
  input logic sync_q,
  input logic sdout_o
);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q |-> (!sclk_q && !sdout_o));

  a_r6_lead_clock_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> !sclk_q);

  a_r7_data_on_inactive_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && $past(sync_q) && (sdout_o != $past(sdout_o))) |-> $fell(sclk_q));

  a_r3_start_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync_q) && !$past(read_during_i)) |-> !$past(busy_i));

  a_r4_start_during_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync_q) && $past(read_during_i)) |-> $past(busy_i));
endmodule

bind conv_serial_master conv_serial_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .read_during_i(read_during_i),
  .sclk_q(sclk_q), .sync_q(sync_q), .sdout_o(sdout_o)
);

// File: tb/conv_serial_master_tb.sv
module conv_serial_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] result_i = '0;
  logic        done_i = 1'b0;
  logic        busy_i = 1'b0;
  logic [1:0]  div_sel_i = '0;
  logic        read_during_i = 1'b0;
  logic        sclk_inv_i = 1'b0;
  logic        sync_inv_i = 1'b0;
  logic        sclk_o, sync_o, sdout_o;

  conv_serial_master dut_i (
    .clk(clk), .rst_n(rst_n), .result_i(result_i), .done_i(done_i),
    .busy_i(busy_i), .div_sel_i(div_sel_i), .read_during_i(read_during_i),
    .sclk_inv_i(sclk_inv_i), .sync_inv_i(sync_inv_i),
    .sclk_o(sclk_o), .sync_o(sync_o), .sdout_o(sdout_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] d);
    return 1 << d;
  endfunction

  logic [15:0] expq [0:7];
  int wp = 0, rp = 0;
  task automatic push_exp(input logic [15:0] w);
    expq[wp % 8] = w;
    wp++;
  endtask

  int frames = 0, idle_bad = 0;
  bit sc_p = 0, sy_p = 0, in_fr = 0, first = 0, hw_bad = 0, start_busy = 0;
  int t = 0, t_r = 0, t_f = 0, lead = 0, nb = 0;
  logic [15:0] wd = '0;

  always @(negedge clk) begin
    bit sc, sy;
    sc = sclk_o ^ sclk_inv_i;
    sy = sync_o ^ sync_inv_i;
    if (rst_n) begin
      if (sy && !sy_p) begin
        in_fr = 1; t = 0; nb = 0; wd = '0; first = 1; hw_bad = 0; start_busy = busy_i;
      end else if (in_fr) t++;
      if (sy) begin
        if (sc && !sc_p) begin
          if (first) begin lead = t; first = 0; end
          t_r = t; nb++; wd = {wd[14:0], sdout_o};
        end
        if (!sc && sc_p) begin
          if (t - t_r != half_of(div_sel_i)) hw_bad = 1;
          t_f = t;
        end
      end else begin
        if (sc || sdout_o) idle_bad++;
      end
      if (!sy && sy_p && in_fr) begin
        logic [15:0] e;
        e = expq[rp % 8];
        rp++;
        chk(nb == 16, "R1 bit count", nb, 16);
        chk(wd == e, "R1/R8 word", int'(wd), int'(e));
        chk(!hw_bad, "R2 clock high width", int'(hw_bad), 0);
        chk(lead == half_of(div_sel_i), "R6 lead", lead, half_of(div_sel_i));
        chk(t - t_f == half_of(div_sel_i), "R6 trail", t - t_f, half_of(div_sel_i));
        chk(start_busy == read_during_i, "R3/R4 start busy", int'(start_busy), int'(read_during_i));
        in_fr = 0;
        frames++;
      end
    end
    sc_p = sc;
    sy_p = sy;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic done_pulse(input logic [15:0] w);
    result_i = w; done_i = 1'b1;
    push_exp(w);
    tick(1);
    done_i = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    while (frames < n) tick(1);
  endtask

  task automatic one_frame(input bit mode, input logic [15:0] w, input logic [1:0] d,
                           input bit ci, input bit si);
    int target;
    target = frames + 1;
    read_during_i = mode; div_sel_i = d; sclk_inv_i = ci; sync_inv_i = si;
    tick(2);
    if (!mode) begin
      busy_i = 1'b1;
      tick(3);
      done_pulse(w);
      tick(12);
      chk(sync_o == si, "R3 held while busy high", int'(sync_o), int'(si));
      busy_i = 1'b0;
      wait_frames(target);
    end else begin
      busy_i = 1'b0;
      done_pulse(w);
      tick(6);
      chk(sync_o == si, "R4 held while busy low", int'(sync_o), int'(si));
      busy_i = 1'b1;
      wait_frames(target);
      busy_i = 1'b0;
    end
    tick(2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    chk(sclk_o == 1'b0 && sync_o == 1'b0, "R9 reset lines", {sclk_o, sync_o}, 0);
    chk(sdout_o == 1'b0, "R9 reset data", int'(sdout_o), 0);
    rst_n = 1'b1;
    tick(2);
    sclk_inv_i = 1'b1; sync_inv_i = 1'b1;
    tick(1);
    chk(sclk_o && sync_o, "R5 inverted idle levels", {sclk_o, sync_o}, 3);
    sclk_inv_i = 1'b0; sync_inv_i = 1'b0;

    one_frame(1'b0, 16'h0000, 2'd0, 1'b0, 1'b0);
    one_frame(1'b0, 16'hFFFF, 2'd3, 1'b0, 1'b0);
    one_frame(1'b1, 16'h8001, 2'd1, 1'b1, 1'b0);
    one_frame(1'b1, 16'h5555, 2'd2, 1'b0, 1'b1);
    one_frame(1'b0, 16'hAAAA, 2'd1, 1'b1, 1'b1);

    // R8: second result arrives mid-frame
    begin
      int target;
      target = frames + 2;
      read_during_i = 1'b0; div_sel_i = 2'd1; sclk_inv_i = 1'b0; sync_inv_i = 1'b0;
      busy_i = 1'b0;
      tick(2);
      done_pulse(16'hC3A5);
      tick(20);
      chk(sync_o == 1'b1, "R8 first frame running", int'(sync_o), 1);
      done_pulse(16'h1E0F);
      wait_frames(target);
      tick(2);
    end

    for (int i = 0; i < 40; i++) begin
      logic [15:0] w;
      logic [1:0] d;
      bit m, ci, si;
      w = 16'($urandom); d = 2'($urandom); m = 1'($urandom);
      ci = 1'($urandom); si = 1'($urandom);
      one_frame(m, w, d, ci, si);
    end

    chk(idle_bad == 0, "R9 idle lines quiet", idle_bad, 0);
    chk(rp == wp, "R1 all frames seen", rp, wp);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", frames, wp);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule